// File: doc/BRIEF.md
# GF(16) Double-Error-Correcting Block Decoder

This block decodes 15-symbol Reed-Solomon words with 11 data symbols and 4 check symbols. Each symbol is 4 bits wide and the field is GF(16) built on x^4+x+1, with α = 2. Symbols enter one per clock. The first symbol of a word carries a start strobe and is the coefficient of highest degree (x^14). The next 14 symbols follow on consecutive cycles. Valid words are multiples of g(x) = (x+1)(x+α)(x+α²)(x+α³). The data symbols come first and the check symbols last.

Four syndromes are accumulated as the word arrives. When any syndrome is nonzero, an iterative Berlekamp-Massey unit builds the error locator, running one iteration per cycle. A parallel root search over all 15 positions follows in a single cycle. While the word is held in a fixed delay line, a Forney evaluator corrects each symbol as it leaves. Up to two wrong symbols are repaired. Words that cannot be decoded leave unchanged and carry a failure flag. Latency is constant, so words can arrive back to back or with idle gaps between them.

Top module: `rsd_decoder`

## Requirements
- R1: Syndrome S_j equals r(α^j) for j = 0..3, with the symbol that arrives with the start strobe taken as the coefficient of x^14. A word that is a multiple of g(x) produces four zero syndromes.
- R2: `rs_err_flag` is held for all 15 output cycles of a word. It is 1 exactly when at least one of that word's syndromes is nonzero.
- R3: A single wrong symbol, at any of the 15 positions and with any nonzero error value, is restored exactly on the output.
- R4: Any two wrong symbols at distinct positions are restored exactly on the output.
- R5: An error-free word leaves unchanged with both flags low. The locator iteration is not run for it, so its locator stays 1.
- R6: If the locator length exceeds 2, or the number of locator roots differs from the locator length, the word leaves exactly as received and `rs_fail_flag` is 1 for its 15 output cycles. Otherwise the output is a codeword.
- R7: `rs_out_start` is a one-cycle pulse 21 cycles after `rs_in_start`. Output symbol i appears 21 cycles after input symbol i, in arrival order.
- R8: Words presented back to back (a start every 15 cycles) or with idle gaps between them are each decoded independently.
- R9: After reset, `rs_out_start`, `rs_out_sym`, `rs_err_flag` and `rs_fail_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rs_in_start | input | 1 | High with the first symbol of a received word |
| rs_in_sym | input | 4 | Received symbol, one per cycle |
| rs_out_start | output | 1 | High with the first corrected symbol |
| rs_out_sym | output | 4 | Corrected symbol stream |
| rs_err_flag | output | 1 | Word had nonzero syndromes (held per output word) |
| rs_fail_flag | output | 1 | Word was not correctable and passed through unchanged (held per output word) |

## Verification
Every result of a word is due at a fixed offset from its input start strobe. The start pulse comes 21 cycles after the input start. Corrected symbol i comes 21+i cycles after it. Both flags are valid from the output start through the 14 cycles after it. The bench records the cycle count at which each input start is driven. It then requires the matching output start at exactly that count plus 21, and reads the 15 symbols and both flags on the falling edges of those 15 cycles. The words run back to back, with one idle gap, so that the result registers of one word are checked while the next word is already being processed.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
    localparam int SYM_W   = 4;
    localparam int NSYM    = 15;
    localparam int NSYN    = 4;
    localparam int T_CORR  = NSYN / 2;
    localparam int LAM_N   = NSYN + 1;
    localparam int IDX_W   = $clog2(NSYM);
    localparam int LEN_W   = $clog2(LAM_N + 1);
    localparam int STEP_W  = $clog2(NSYN);
    // syndrome accumulation + one locator step per syndrome + root search
    localparam int DLY     = NSYM + NSYN + 1;
    localparam int LATENCY = DLY + 1;

    typedef logic [SYM_W-1:0] gf_t;

    // reduction term for x^4 = x + 1
    localparam gf_t FIELD_LOW = 4'h3;

    function automatic gf_t gf_mul(gf_t a, gf_t b);
        gf_t acc;
        gf_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[SYM_W-2:0], 1'b0} ^ (sh[SYM_W-1] ? FIELD_LOW : '0);
        end
        return acc;
    endfunction

    function automatic gf_t gf_pow(int e);
        gf_t r;
        int  em;
        r  = gf_t'(1);
        em = e % NSYM;
        for (int i = 0; i < NSYM; i++) begin
            if (i < em) r = gf_mul(r, gf_t'(2));
        end
        return r;
    endfunction

    // a^(q-2); zero maps to zero
    function automatic gf_t gf_inv(gf_t a);
        gf_t r;
        r = gf_t'(1);
        for (int i = 0; i < NSYM - 1; i++) r = gf_mul(r, a);
        return r;
    endfunction
endpackage

// File: rtl/rsd_syndrome.sv
module rsd_syndrome
    import rsd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_start,
    input  gf_t              in_sym,
    output gf_t [NSYN-1:0]   syn_o,
    output logic             syn_vld_o
);
    typedef struct packed {
        logic             act;
        logic [IDX_W-1:0] idx;
        gf_t [NSYN-1:0]   acc;
        gf_t [NSYN-1:0]   syn;
        logic             vld;
    } syn_st_t;

    syn_st_t q, d;
    gf_t [NSYN-1:0] horner;
    logic           cur_act;
    logic [IDX_W-1:0] cur_idx;

    // one Horner cell per syndrome, evaluated at alpha^j
    for (genvar j = 0; j < NSYN; j++) begin : g_cell
        localparam gf_t ROOT = gf_pow(j);
        assign horner[j] = gf_mul(in_start ? gf_t'(0) : q.acc[j], ROOT) ^ in_sym;
    end

    always_comb begin
        d       = q;
        d.vld   = 1'b0;
        cur_act = in_start | q.act;
        cur_idx = in_start ? '0 : q.idx;
        if (cur_act) begin
            d.acc = horner;
            if (cur_idx == IDX_W'(NSYM - 1)) begin
                d.syn = horner;
                d.vld = 1'b1;
                d.act = 1'b0;
                d.idx = '0;
            end else begin
                d.act = 1'b1;
                d.idx = cur_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign syn_o     = q.syn;
    assign syn_vld_o = q.vld;

    // a word takes 15 cycles, so a completed syndrome set never repeats next cycle
    p_syn_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |=> !q.vld);
    // the symbol counter never passes the last position of a word
    p_idx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.act |-> (q.idx <= IDX_W'(NSYM - 1)));
endmodule

// File: rtl/rsd_bm.sv
module rsd_bm
    import rsd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  gf_t [NSYN-1:0]     syn_i,
    input  logic               syn_vld_i,
    output gf_t [LAM_N-1:0]    lam_o,
    output logic [LEN_W-1:0]   len_o,
    output logic               err_o,
    output logic               done_o
);
    typedef struct packed {
        logic              run;
        logic [STEP_W-1:0] step;
        logic              err;
        logic              done;
        logic [LEN_W-1:0]  len;
        gf_t [LAM_N-1:0]   lam;
        gf_t [LAM_N-1:0]   bp;
    } bm_st_t;

    bm_st_t q, d;
    logic             go;
    logic             act;
    int               r;
    gf_t [LAM_N-1:0]  lam_c, bp_c, lam_n, bp_n;
    logic [LEN_W-1:0] len_c, len_n;
    gf_t              disc, dinv;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        go     = 1'b0;
        r      = 0;
        act    = q.err;
        lam_c  = q.lam;
        bp_c   = q.bp;
        len_c  = q.len;
        if (syn_vld_i) begin
            go       = 1'b1;
            act      = |syn_i;
            d.err    = act;
            lam_c    = '0;
            lam_c[0] = gf_t'(1);
            bp_c     = '0;
            bp_c[0]  = gf_t'(1);
            len_c    = '0;
        end else if (q.run) begin
            go = 1'b1;
            r  = int'(q.step);
        end

        disc = '0;
        for (int i = 0; i < NSYN; i++) begin
            if (i <= r) disc = disc ^ gf_mul(lam_c[i], syn_i[STEP_W'(r - i)]);
        end
        dinv = gf_inv(disc);

        lam_n = lam_c;
        bp_n  = {bp_c[LAM_N-2:0], gf_t'(0)};
        len_n = len_c;
        if (act && disc != '0) begin
            for (int i = 1; i < LAM_N; i++) lam_n[i] = lam_c[i] ^ gf_mul(disc, bp_c[i-1]);
            if (2 * int'(len_c) <= r) begin
                len_n = LEN_W'(r + 1 - int'(len_c));
                for (int i = 0; i < LAM_N; i++) bp_n[i] = gf_mul(dinv, lam_c[i]);
            end
        end

        if (go) begin
            d.lam  = lam_n;
            d.bp   = bp_n;
            d.len  = len_n;
            d.step = STEP_W'(r + 1);
            d.run  = (r != NSYN - 1);
            d.done = (r == NSYN - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lam_o  = q.lam;
    assign len_o  = q.len;
    assign err_o  = q.err;
    assign done_o = q.done;

    // a clean word leaves the locator at 1 with length 0
    p_clean_lambda_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !q.err) |-> (q.lam == {{(LAM_N-1){gf_t'(0)}}, gf_t'(1)} && q.len == '0));
    // completion is a single pulse per word
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
endmodule

// File: rtl/rsd_chien.sv
module rsd_chien
    import rsd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done_i,
    input  gf_t [LAM_N-1:0]    lam_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               err_i,
    input  gf_t                syn0_i,
    input  gf_t                syn1_i,
    output logic [NSYM-1:0]    roots_o,
    output logic               fail_o,
    output logic               err_o,
    output gf_t                om0_o,
    output gf_t                om1_o,
    output gf_t                l1inv_o
);
    typedef struct packed {
        logic [NSYM-1:0] roots;
        logic            fail;
        logic            err;
        gf_t             om0;
        gf_t             om1;
        gf_t             l1inv;
    } ch_st_t;

    ch_st_t q, d;
    logic [NSYM-1:0] root_c;
    int              cnt;

    // one locator evaluator per position, at alpha^(-p)
    for (genvar p = 0; p < NSYM; p++) begin : g_pos
        gf_t val;
        always_comb begin
            val = '0;
            for (int i = 0; i < LAM_N; i++)
                val = val ^ gf_mul(lam_i[i], gf_pow(((NSYM - p) * i) % NSYM));
        end
        assign root_c[p] = (val == '0);
    end

    always_comb begin
        d   = q;
        cnt = $countones(root_c);
        if (done_i) begin
            d.roots = root_c;
            d.err   = err_i;
            d.fail  = (int'(len_i) > T_CORR) || (cnt != int'(len_i));
            d.om0   = syn0_i;
            d.om1   = syn1_i ^ gf_mul(syn0_i, lam_i[1]);
            d.l1inv = gf_inv(lam_i[1]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign roots_o = q.roots;
    assign fail_o  = q.fail;
    assign err_o   = q.err;
    assign om0_o   = q.om0;
    assign om1_o   = q.om1;
    assign l1inv_o = q.l1inv;

    // a word with zero syndromes can never be declared uncorrectable
    p_clean_nofail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !q.err |-> !q.fail);
endmodule

// File: rtl/rsd_correct.sv
module rsd_correct
    import rsd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_start,
    input  gf_t              in_sym,
    input  logic [NSYM-1:0]  roots_i,
    input  logic             fail_i,
    input  logic             err_i,
    input  gf_t              om0_i,
    input  gf_t              om1_i,
    input  gf_t              l1inv_i,
    output logic             out_start_o,
    output gf_t              out_sym_o,
    output logic             out_err_o,
    output logic             out_fail_o
);
    typedef struct packed {
        logic [DLY-1:0][SYM_W:0] dly;
        logic                    act;
        logic [IDX_W-1:0]        pos;
        logic                    start;
        gf_t                     sym;
        logic                    err;
        logic                    fail;
    } co_st_t;

    co_st_t q, d;
    logic             tstart;
    gf_t              tsym;
    logic             act_cur;
    logic [IDX_W-1:0] pos_cur;
    gf_t              xloc, xinv, omv, ev;
    logic             fix;

    always_comb begin
        d       = q;
        d.dly   = {q.dly[DLY-2:0], {in_start, in_sym}};
        tstart  = q.dly[DLY-1][SYM_W];
        tsym    = q.dly[DLY-1][SYM_W-1:0];
        act_cur = tstart | q.act;
        pos_cur = tstart ? IDX_W'(NSYM - 1) : q.pos;

        xloc = gf_pow(int'(pos_cur));
        xinv = gf_pow(NSYM - int'(pos_cur));
        omv  = om0_i ^ gf_mul(om1_i, xinv);
        ev   = gf_mul(gf_mul(xloc, omv), l1inv_i);
        fix  = act_cur && roots_i[pos_cur] && !fail_i;

        d.sym   = tsym ^ (fix ? ev : gf_t'(0));
        d.start = tstart;
        if (tstart) begin
            d.err  = err_i;
            d.fail = fail_i;
        end
        d.act = act_cur && (pos_cur != '0);
        if (act_cur) d.pos = pos_cur - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_start_o = q.start;
    assign out_sym_o   = q.sym;
    assign out_err_o   = q.err;
    assign out_fail_o  = q.fail;

    // the delayed start leaves through exactly one output register
    p_start_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tstart |=> out_start_o);
    // an uncorrectable word leaves bit for bit as received
    p_pass_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cur && fail_i) |=> (out_sym_o == $past(tsym)));
endmodule

// File: rtl/rsd_decoder.sv
module rsd_decoder
    import rsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rs_in_start,
    input  logic [3:0] rs_in_sym,
    output logic       rs_out_start,
    output logic [3:0] rs_out_sym,
    output logic       rs_err_flag,
    output logic       rs_fail_flag
);
    gf_t [NSYN-1:0]   syn;
    logic             syn_vld;
    gf_t [LAM_N-1:0]  lam;
    logic [LEN_W-1:0] lam_len;
    logic             bm_err, bm_done;
    logic [NSYM-1:0]  roots;
    logic             ch_fail, ch_err;
    gf_t              om0, om1, l1inv;

    rsd_syndrome u_syn (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_start  (rs_in_start),
        .in_sym    (rs_in_sym),
        .syn_o     (syn),
        .syn_vld_o (syn_vld)
    );

    rsd_bm u_bm (
        .clk       (clk),
        .rst_n     (rst_n),
        .syn_i     (syn),
        .syn_vld_i (syn_vld),
        .lam_o     (lam),
        .len_o     (lam_len),
        .err_o     (bm_err),
        .done_o    (bm_done)
    );

    rsd_chien u_chien (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (bm_done),
        .lam_i   (lam),
        .len_i   (lam_len),
        .err_i   (bm_err),
        .syn0_i  (syn[0]),
        .syn1_i  (syn[1]),
        .roots_o (roots),
        .fail_o  (ch_fail),
        .err_o   (ch_err),
        .om0_o   (om0),
        .om1_o   (om1),
        .l1inv_o (l1inv)
    );

    rsd_correct u_corr (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_start    (rs_in_start),
        .in_sym      (rs_in_sym),
        .roots_i     (roots),
        .fail_i      (ch_fail),
        .err_i       (ch_err),
        .om0_i       (om0),
        .om1_i       (om1),
        .l1inv_i     (l1inv),
        .out_start_o (rs_out_start),
        .out_sym_o   (rs_out_sym),
        .out_err_o   (rs_err_flag),
        .out_fail_o  (rs_fail_flag)
    );
endmodule

// File: tb/tb_rsd_decoder.sv
module tb_rsd_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 40;
    localparam int LAT        = 21;
    localparam int WD_CYCLES  = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rs_in_start = 1'b0;
    logic [3:0] rs_in_sym = '0;
    logic       rs_out_start;
    logic [3:0] rs_out_sym;
    logic       rs_err_flag;
    logic       rs_fail_flag;

    rsd_decoder dut (
        .clk(clk), .rst_n(rst_n),
        .rs_in_start(rs_in_start), .rs_in_sym(rs_in_sym),
        .rs_out_start(rs_out_start), .rs_out_sym(rs_out_sym),
        .rs_err_flag(rs_err_flag), .rs_fail_flag(rs_fail_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit wd_hit = 1'b0;

    logic [3:0] tx  [NB][15];
    logic [3:0] rx  [NB][15];
    logic [3:0] got [15];
    int         nerr [NB];
    int         t_in [NB];
    logic [3:0] gpoly [5];

    function automatic logic [3:0] gmul(logic [3:0] a, logic [3:0] b);
        logic [3:0] p = '0;
        logic [3:0] s = a;
        for (int i = 0; i < 4; i++) begin
            if (b[i]) p ^= s;
            s = {s[2:0], 1'b0} ^ (s[3] ? 4'h3 : 4'h0);
        end
        return p;
    endfunction

    function automatic logic [3:0] gpow(int e);
        logic [3:0] r = 4'h1;
        for (int i = 0; i < e % 15; i++) r = gmul(r, 4'h2);
        return r;
    endfunction

    task automatic build_gen();
        for (int i = 0; i < 5; i++) gpoly[i] = '0;
        gpoly[0] = 4'h1;
        for (int j = 0; j < 4; j++) begin
            logic [3:0] nw [5];
            for (int i = 0; i < 5; i++) nw[i] = gmul(gpoly[i], gpow(j));
            for (int i = 1; i < 5; i++) nw[i] ^= gpoly[i-1];
            for (int i = 0; i < 5; i++) gpoly[i] = nw[i];
        end
    endtask

    task automatic encode(int b);
        logic [3:0] par [4];
        for (int i = 0; i < 4; i++) par[i] = '0;
        for (int k = 0; k < 11; k++) begin
            logic [3:0] fb = tx[b][k] ^ par[3];
            for (int i = 3; i > 0; i--) par[i] = par[i-1] ^ gmul(fb, gpoly[i]);
            par[0] = gmul(fb, gpoly[0]);
        end
        for (int i = 0; i < 4; i++) tx[b][11+i] = par[3-i];
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cmp_word(int b, bit vs_rx, string req);
        int bad = -1;
        for (int k = 0; k < 15; k++) begin
            logic [3:0] e = vs_rx ? rx[b][k] : tx[b][k];
            if (bad < 0 && got[k] != e) bad = k;
        end
        if (bad < 0) chk(1'b1, req, "word", 0, 0);
        else chk(1'b0, req, $sformatf("word %0d symbol %0d", b, bad), int'(got[bad]),
                 int'(vs_rx ? rx[b][bad] : tx[b][bad]));
    endtask

    function automatic bit got_is_codeword();
        for (int j = 0; j < 4; j++) begin
            logic [3:0] s = '0;
            for (int k = 0; k < 15; k++) s = gmul(s, gpow(j)) ^ got[k];
            if (s != '0) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic make_word(int b);
        for (int k = 0; k < 11; k++) tx[b][k] = (b == 0) ? 4'h0 : 4'($urandom_range(0, 15));
        encode(b);
        for (int k = 0; k < 15; k++) rx[b][k] = tx[b][k];
        case (b)
            0, 1: nerr[b] = 0;
            2: begin nerr[b] = 1; rx[b][0]  ^= 4'h9; end
            3: begin nerr[b] = 1; rx[b][14] ^= 4'h1; end
            4: begin nerr[b] = 2; rx[b][5] ^= 4'hF; rx[b][6] ^= 4'h7; end
            5: begin nerr[b] = 2; rx[b][0] ^= 4'h3; rx[b][14] ^= 4'hC; end
            default: begin
                int used [15];
                nerr[b] = (b % 5 == 0) ? 3 : (b % 3);
                for (int k = 0; k < 15; k++) used[k] = 0;
                for (int e = 0; e < nerr[b]; e++) begin
                    int p = $urandom_range(0, 14);
                    while (used[p] != 0) p = $urandom_range(0, 14);
                    used[p] = 1;
                    rx[b][p] ^= 4'($urandom_range(1, 15));
                end
            end
        endcase
    endtask

    task automatic drive();
        for (int b = 0; b < NB; b++) begin
            make_word(b);
            if (b == 10) begin
                repeat (3) begin
                    @(negedge clk);
                    rs_in_start = 1'b0;
                    rs_in_sym   = '0;
                end
            end
            for (int k = 0; k < 15; k++) begin
                @(negedge clk);
                rs_in_start = (k == 0);
                rs_in_sym   = rx[b][k];
                if (k == 0) t_in[b] = cyc;
            end
        end
        @(negedge clk);
        rs_in_start = 1'b0;
        rs_in_sym   = '0;
    endtask

    task automatic monitor();
        for (int b = 0; b < NB; b++) begin
            bit ef, ff;
            @(negedge clk);
            while (!rs_out_start) @(negedge clk);
            // R7 fixed latency; R8 for later words of a back-to-back stream
            chk(cyc - t_in[b] == LAT, (b == 0) ? "R7" : "R8", "latency", cyc - t_in[b], LAT);
            ef = rs_err_flag;
            ff = rs_fail_flag;
            got[0] = rs_out_sym;
            for (int k = 1; k < 15; k++) begin
                @(negedge clk);
                got[k] = rs_out_sym;
                if (rs_err_flag != ef || rs_fail_flag != ff) chk(1'b0, "R2", "flag not held", k, 0);
            end
            chk(ef == (nerr[b] > 0), "R2", "err flag", int'(ef), int'(nerr[b] > 0));
            if (nerr[b] <= 2) begin
                chk(ff == 1'b0, "R6", "fail flag on correctable word", int'(ff), 0);
                if (nerr[b] == 0)      cmp_word(b, 1'b0, "R5");
                else if (nerr[b] == 1) cmp_word(b, 1'b0, "R3");
                else                   cmp_word(b, 1'b0, "R4");
            end else if (ff) begin
                cmp_word(b, 1'b1, "R6");
            end else begin
                chk(got_is_codeword(), "R6", "output not a codeword", 0, 1);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        build_gen();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(rs_out_start == 1'b0, "R9", "out start", int'(rs_out_start), 0);
        chk(rs_out_sym == 4'h0, "R9", "out sym", int'(rs_out_sym), 0);
        chk(rs_err_flag == 1'b0 && rs_fail_flag == 1'b0, "R9", "flags",
            int'({rs_err_flag, rs_fail_flag}), 0);
        // R1 is exercised by every word: zero syndromes on clean words, exact fixes otherwise
        fork
            begin
                fork
                    drive();
                    monitor();
                join
            end
            begin
                repeat (WD_CYCLES) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) chk(1'b0, "R7", "watchdog expired", cyc, WD_CYCLES);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule